// File: doc/BRIEF.md
# I/O Compensation Code Selector

This block decides which 8-bit drive-strength code reaches a group of I/O buffers. The code has two halves: the upper nibble trims the PMOS pull-up and the lower nibble trims the NMOS pull-down. Three sources are possible:

- a fixed default code, set by a parameter;
- the live code measured by a compensation cell, which is modelled here as input ports with a valid strobe;
- a code that software writes into a trim register.

Software reaches the block through a small register port. A control word holds the cell enable, the source select and a read-only ready flag. A read-only value register keeps the last measured code, and a trim register holds the software code.

The cell can only report ready while its oscillator request input is high. Power-mode inputs override the normal selection. Standby switches the cell off and puts the default code on the pads. Sleep and stop leave the current selection untouched.

The usual software flow is:

1. Enable the cell and wait for ready.
2. Read the measured value and copy it into the trim register.
3. Set the select bit and then disable the cell.

The pads keep the trimmed code after the cell stops.

Top module: `iocomp_code_sel`

## Requirements
- R1: After reset the control word reads 0x02 (select=1, enable=0, ready=0), the trim register reads 0x78, the value register reads 0x00 and the pads carry 0x78.
- R2: Every code is laid out with bits 7:4 as the PMOS half and bits 3:0 as the NMOS half. The PMOS half drives pad_pcode and the NMOS half drives pad_ncode.
- R3: When select is 1 and standby is low, the pads carry the trim register (address 2).
- R4: When select is 0, the cell is enabled and ready is 1, the pads carry the measured value and follow each new valid measurement.
- R5: When select is 0 and the cell is disabled or not ready, the pads carry the default code 0x78.
- R6: Ready (control bit 7) sets only when the cell is enabled, standby is low, osc_en is high and cell_valid is high. It clears one clock after enable, osc_en or standby stops holding it.
- R7: The value register (address 1) captures cell_code on each valid measurement while the cell is running. It keeps its last value after the cell is disabled.
- R8: Writes to the value register have no effect on it.
- R9: Standby forces the default code onto the pads and keeps the cell off. The stored enable bit is kept.
- R10: Sleep and stop do not change the applied code or the register contents.
- R11: The pad code is registered and changes on the clock edge that follows a change of its source or select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 value, 2 trim |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| cell_code | input | 8 | Code measured by the compensation cell |
| cell_valid | input | 1 | Measurement valid |
| osc_en | input | 1 | Cell oscillator running |
| mode_sleep | input | 1 | Sleep mode |
| mode_stop | input | 1 | Stop mode |
| mode_standby | input | 1 | Standby mode |
| ready | output | 1 | Cell ready flag |
| meas_value | output | 8 | Last captured measurement |
| pad_pcode | output | 4 | PMOS code applied to pads |
| pad_ncode | output | 4 | NMOS code applied to pads |

## Verification
A stuck or stale ready flag shows on the pads within one clock as the default code in place of the measured code, or the other way round. A corrupted value or trim register appears in the very next pad update when that source is selected, and also on read-back. Standby and enable handling is observed through the pads and the ready flag every cycle, by comparison with a behavioural model.

// File: rtl/iocomp_code_sel.sv
module iocomp_code_sel #(
  parameter int CW = 8,
  parameter logic [7:0] DEF_CODE = 8'h78,
  parameter logic [7:0] TRIM_RST = 8'h78
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic [CW-1:0] cell_code,
  input  logic          cell_valid,
  input  logic          osc_en,
  input  logic          mode_sleep,
  input  logic          mode_stop,
  input  logic          mode_standby,
  output logic          ready,
  output logic [CW-1:0] meas_value,
  output logic [CW/2-1:0] pad_pcode,
  output logic [CW/2-1:0] pad_ncode
);
  localparam int HW = CW / 2;

  logic          en_q, sel_q, rdy_q;
  logic [CW-1:0] trim_q, meas_q, pad_q, pad_d;
  logic          cell_on, sample;

  assign cell_on = en_q & ~mode_standby;
  assign sample  = cell_on & osc_en & cell_valid;

  always_comb begin
    if (mode_standby)         pad_d = DEF_CODE;
    else if (sel_q)           pad_d = trim_q;
    else if (cell_on & rdy_q) pad_d = meas_q;
    else                      pad_d = DEF_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= 1'b1;
      trim_q <= TRIM_RST;
      meas_q <= '0;
      rdy_q  <= 1'b0;
      pad_q  <= DEF_CODE;
    end else begin
      pad_q <= pad_d;
      rdy_q <= cell_on & osc_en & (rdy_q | cell_valid);
      if (sample) meas_q <= cell_code;
      if (reg_wr && reg_addr == 2'd0) begin
        en_q  <= reg_wdata[0];
        sel_q <= reg_wdata[1];
      end
      if (reg_wr && reg_addr == 2'd2) trim_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {rdy_q, {(CW-3){1'b0}}, sel_q, en_q};
      2'd1:    reg_rdata = meas_q;
      2'd2:    reg_rdata = trim_q;
      default: reg_rdata = '0;
    endcase
  end

  assign ready      = rdy_q;
  assign meas_value = meas_q;
  assign pad_pcode  = pad_q[CW-1:HW];
  assign pad_ncode  = pad_q[HW-1:0];

  // R9
  standby_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_standby |=> {pad_pcode, pad_ncode} == DEF_CODE);
  // R6
  rdy_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !ready);
  // R6
  rdy_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || mode_standby) |=> !ready);
  // R8
  meas_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && !cell_valid) |=> $stable(meas_value));
  // R3
  trim_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !mode_standby) |=> {pad_pcode, pad_ncode} == $past(trim_q));
  // R10
  lowpwr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sleep || mode_stop) && !mode_standby && !reg_wr && sel_q)
      |=> {pad_pcode, pad_ncode} == $past(trim_q));
  // R5
  default_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && !en_q) |=> {pad_pcode, pad_ncode} == DEF_CODE);
endmodule

// File: tb/iocomp_code_sel_tb.sv
module iocomp_code_sel_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, cell_code = 0, meas_value;
  logic cell_valid = 0, osc_en = 0, mode_sleep = 0, mode_stop = 0, mode_standby = 0;
  logic ready;
  logic [3:0] pad_pcode, pad_ncode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iocomp_code_sel u_dut (.*);

  // behavioural reference
  bit m_en, m_sel, m_rdy;
  logic [7:0] m_trim, m_meas, m_pad;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sel = 1; m_rdy = 0; m_trim = 8'h78; m_meas = 0; m_pad = 8'h78;
    end else begin
      bit running;
      logic [7:0] np;
      running = m_en && !mode_standby;
      np = 8'h78;
      if (!mode_standby) begin
        if (m_sel) np = m_trim;
        else if (running && m_rdy) np = m_meas;
      end
      m_pad = np;
      if (running && osc_en && cell_valid) m_meas = cell_code;
      m_rdy = running && osc_en && (m_rdy || cell_valid);
      if (reg_wr && reg_addr == 0) begin m_en = reg_wdata[0]; m_sel = reg_wdata[1]; end
      if (reg_wr && reg_addr == 2) m_trim = reg_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R11 per-cycle comparison with the model
  always @(negedge clk) if (rst_n) begin
    check({pad_pcode, pad_ncode} == m_pad, "R11 pad vs model", {pad_pcode, pad_ncode}, m_pad);
    check(ready == m_rdy, "R6 ready vs model", ready, m_rdy);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; #0.5;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] pad();
    return {pad_pcode, pad_ncode};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    rd(0, 8'h02, "R1 ctrl reset");
    rd(2, 8'h78, "R1 trim reset");
    rd(1, 8'h00, "R1 value reset");
    check(pad() == 8'h78, "R1 pad reset", pad(), 8'h78);
    check(ready == 0, "R1 ready reset", ready, 0);

    wr(2, 8'hA5); cyc(1);
    check(pad_pcode == 4'hA, "R2 pmos half", pad_pcode, 4'hA);
    check(pad_ncode == 4'h5, "R3 trim applied nmos", pad_ncode, 4'h5);

    cell_code = 8'h3C; cell_valid = 1; osc_en = 0;
    wr(0, 8'h01); cyc(4);
    check(ready == 0, "R6 no ready without osc", ready, 0);
    check(pad() == 8'h78, "R5 default while not ready", pad(), 8'h78);
    rd(1, 8'h00, "R6 no capture without osc");

    osc_en = 1; cyc(1);
    check(ready == 1, "R6 ready sets", ready, 1);
    cyc(1);
    check(pad() == 8'h3C, "R4 measured applied", pad(), 8'h3C);
    rd(1, 8'h3C, "R7 value captured");

    wr(1, 8'hFF); cell_valid = 0; cyc(1);
    rd(1, 8'h3C, "R8 value write ignored");
    check(meas_value == 8'h3C, "R8 value port", meas_value, 8'h3C);

    cell_code = 8'h4D; cell_valid = 1; cyc(2);
    check(pad() == 8'h4D, "R4 follows new measurement", pad(), 8'h4D);

    mode_standby = 1; cyc(2);
    check(pad() == 8'h78, "R9 standby default", pad(), 8'h78);
    check(ready == 0, "R9 standby not ready", ready, 0);
    rd(0, 8'h01, "R9 enable kept");
    mode_standby = 0; cyc(3);
    check(pad() == 8'h4D, "R9 recovery", pad(), 8'h4D);

    mode_sleep = 1; cyc(3);
    check(pad() == 8'h4D, "R10 sleep keeps code", pad(), 8'h4D);
    mode_sleep = 0; mode_stop = 1; cyc(3);
    check(pad() == 8'h4D, "R10 stop keeps code", pad(), 8'h4D);
    rd(0, 8'h81, "R10 ctrl unchanged");
    mode_stop = 0;

    cell_valid = 0;
    wr(0, 8'h00); cyc(1);
    check(ready == 0, "R6 ready clears on disable", ready, 0);
    check(pad() == 8'h78, "R5 default when disabled", pad(), 8'h78);
    rd(1, 8'h4D, "R7 value held after disable");

    wr(2, 8'h4D); wr(0, 8'h02); cyc(1);
    check(pad() == 8'h4D, "R3 copied trim applied", pad(), 8'h4D);

    wr(2, 8'h11);
    check(pad() == 8'h4D, "R11 no change before edge", pad(), 8'h4D);
    cyc(1);
    check(pad() == 8'h11, "R11 change after one edge", pad(), 8'h11);

    cyc(2);
    finish_up();
  end
endmodule